// File: doc/BRIEF.md
# Block-in block-out reorder queue

This queue orders data by whole blocks of variable size, while words inside a block can be reached at random. The producer fills the open block by writing words at offsets from the current write base, in any order it likes. Once the block is complete, it issues a push with the block's size. The push commits those words and makes them visible to the consumer. The consumer reads words of the oldest committed data at offsets from the read base, again in any order. It then issues a pull with a size, which releases that many words from the head.

Push sizes and pull sizes are independent, so one side can merge or split the blocks of the other. Take two-dimensional tiles that are addressed in Z-scan order, where the four quadrants of a larger square follow each other. Four small pushed tiles then form one contiguous run, and that run can be pulled as a single large tile. In the same way, one large tile can be pulled as four small ones. The storage is a circular single-clock RAM of 2^ADDR_W words. It is tracked by a write base, a read base and a count of committed words.

Top module: `bibo_queue`

## Requirements
- R1: After reset, `level` is 0, `rd_valid`, `rd_err`, `push_err` and `pull_err` are 0, and a read at offset 0 reports a miss.
- R2: A word written at offset k of the open block, with the words of that block written in any order, is returned by a read at offset k once the block has been pushed and sits at the head.
- R3: After a pull of size s is accepted, a read at offset j returns the word that a read at offset j+s returned before the pull. Blocks therefore leave in the order they were pushed.
- R4: Each push carries its own size, and `level` equals the total of the accepted push sizes minus the total of the accepted pull sizes. It changes on the clock edge that accepts the command.
- R5: A pull size need not match any push size. Several pushed blocks can be read and pulled as one run, and one pushed block can be pulled in pieces.
- R6: A read request yields `rd_valid` high exactly one cycle later, with `rd_data` and `rd_err` in that same cycle. `rd_valid` is low in a cycle that follows no request.
- R7: A read at an offset greater than or equal to `level` returns `rd_data` = 0 with `rd_err` = 1. A read below `level` returns `rd_err` = 0.
- R8: A push whose size exceeds the free space (2^ADDR_W minus `level`) is rejected. `push_err` is 1 in the next cycle, and `level` and the write base do not change.
- R9: A pull whose size exceeds `level` is rejected. `pull_err` is 1 in the next cycle, and `level` and the read base do not change.
- R10: A push and a pull in the same cycle are both judged against the state before that edge. When both are accepted, `level` changes by the push size minus the pull size.
- R11: A write at an offset greater than or equal to the free space is ignored, so committed words keep their values.
- R12: Physical addresses are the base plus the offset, taken modulo 2^ADDR_W. A block that runs past the top of the RAM continues at address 0 without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one word into the open block |
| wr_off | input | ADDR_W | Offset of the word from the write base |
| wr_data | input | DATA_W | Word to store |
| push_en | input | 1 | Commit the open block |
| push_size | input | ADDR_W+1 | Number of words to commit |
| rd_en | input | 1 | Read one word of the committed data |
| rd_off | input | ADDR_W | Offset of the word from the read base |
| pull_en | input | 1 | Release words from the head |
| pull_size | input | ADDR_W+1 | Number of words to release |
| rd_valid | output | 1 | Read result present, one cycle after `rd_en` |
| rd_data | output | DATA_W | Read word, 0 on a miss |
| rd_err | output | 1 | Read offset was not below `level` |
| push_err | output | 1 | Push of the previous cycle was rejected |
| pull_err | output | 1 | Pull of the previous cycle was rejected |
| level | output | ADDR_W+1 | Count of committed words |

## Verification
Each result has a fixed due cycle. `level` changes on the same rising edge that samples a push or a pull. `rd_data`, `rd_valid` and `rd_err` come out of a register one edge after the read request. `push_err` and `pull_err` are also registered and follow their command by one edge. The bench therefore applies every stimulus on a falling edge, and compares every result on the next falling edge, after exactly one rising edge. Separate checks confirm that `rd_valid` drops again one cycle after a single read request.

// File: rtl/bibo_pkg.sv
package bibo_pkg;
   // Outcome of a read request, passed from the pointer logic to the storage.
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_HIT  = 2'd1,
      RD_MISS = 2'd2
   } rd_kind_e;
endpackage

// File: rtl/bibo_ctrl.sv
module bibo_ctrl
   import bibo_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_off,
   input  logic              push_en,
   input  logic [ADDR_W:0]   push_size,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_off,
   input  logic              pull_en,
   input  logic [ADDR_W:0]   pull_size,
   output logic [ADDR_W-1:0] wbase,
   output logic [ADDR_W-1:0] rbase,
   output logic [ADDR_W:0]   level,
   output logic              wr_ok,
   output rd_kind_e          rd_kind,
   output logic              push_err,
   output logic              pull_err
);
   localparam int SZ_W  = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [SZ_W-1:0] DEPTH_V = SZ_W'(DEPTH);

   logic [SZ_W-1:0] free_words;
   logic            push_ok;
   logic            pull_ok;
   logic [SZ_W-1:0] add_amt;
   logic [SZ_W-1:0] sub_amt;
   logic [SZ_W-1:0] level_nxt;

   // Both commands are judged against the state before the edge.
   always_comb begin
      free_words = DEPTH_V - level;
      push_ok    = push_en && (push_size <= free_words);
      pull_ok    = pull_en && (pull_size <= level);
      add_amt    = push_ok ? push_size : '0;
      sub_amt    = pull_ok ? pull_size : '0;
      level_nxt  = level + add_amt - sub_amt;
   end

   // Writes may only land in the uncommitted part of the ring.
   always_comb begin
      wr_ok = wr_en && ({1'b0, wr_off} < free_words);
   end

   always_comb begin
      if (!rd_en)
         rd_kind = RD_IDLE;
      else if ({1'b0, rd_off} < level)
         rd_kind = RD_HIT;
      else
         rd_kind = RD_MISS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbase    <= '0;
         rbase    <= '0;
         level    <= '0;
         push_err <= 1'b0;
         pull_err <= 1'b0;
      end else begin
         level    <= level_nxt;
         push_err <= push_en && !push_ok;
         pull_err <= pull_en && !pull_ok;
         if (push_ok)
            wbase <= wbase + push_size[ADDR_W-1:0];
         if (pull_ok)
            rbase <= rbase + pull_size[ADDR_W-1:0];
      end
   end

   // R4
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= DEPTH_V);

   // R8
   push_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && (push_size > free_words) && !pull_en)
      |=> (push_err && $stable(level) && $stable(wbase)));

   // R9
   pull_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_en && (pull_size > level) && !push_en)
      |=> (pull_err && $stable(level) && $stable(rbase)));

   // R10
   occupancy_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && pull_en && (push_size <= free_words) && (pull_size <= level))
      |=> (level == SZ_W'($past(level) + $past(push_size) - $past(pull_size))));
endmodule

// File: rtl/bibo_store.sv
module bibo_store
   import bibo_pkg::*;
#(
   parameter int ADDR_W         = 6,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  rd_kind_e          rd_kind,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // The parameter picks whether the ring is cleared by reset.
   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++)
                  mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (wr_en)
               mem[wr_addr] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_err   <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= (rd_kind != RD_IDLE);
         rd_err   <= (rd_kind == RD_MISS);
         rd_data  <= (rd_kind == RD_HIT) ? mem[rd_addr] : '0;
      end
   end

   // R6
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kind != RD_IDLE) |=> rd_valid);

   // R6
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_kind == RD_IDLE) |=> !rd_valid);

   // R7
   rd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (rd_valid && (rd_data == '0)));
endmodule

// File: rtl/bibo_queue.sv
module bibo_queue
   import bibo_pkg::*;
#(
   parameter int ADDR_W         = 6,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              push_en,
   input  logic [ADDR_W:0]   push_size,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_off,
   input  logic              pull_en,
   input  logic [ADDR_W:0]   pull_size,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   output logic              push_err,
   output logic              pull_err,
   output logic [ADDR_W:0]   level
);
   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("bibo_queue: ADDR_W must lie in 2..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("bibo_queue: DATA_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] wbase;
   logic [ADDR_W-1:0] rbase;
   logic              wr_ok;
   rd_kind_e          rd_kind;
   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] rd_addr;

   // Modulo addition: the carry out of the top bit is dropped.
   always_comb begin
      wr_addr = wbase + wr_off;
      rd_addr = rbase + rd_off;
   end

   bibo_ctrl #(
      .ADDR_W (ADDR_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_off    (wr_off),
      .push_en   (push_en),
      .push_size (push_size),
      .rd_en     (rd_en),
      .rd_off    (rd_off),
      .pull_en   (pull_en),
      .pull_size (pull_size),
      .wbase     (wbase),
      .rbase     (rbase),
      .level     (level),
      .wr_ok     (wr_ok),
      .rd_kind   (rd_kind),
      .push_err  (push_err),
      .pull_err  (pull_err)
   );

   bibo_store #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ok),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_kind  (rd_kind),
      .rd_addr  (rd_addr),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_err   (rd_err)
   );

   // R11
   guard_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && rd_en && (rd_addr == wr_addr)) |-> (rd_kind != RD_HIT));
endmodule

// File: tb/sim_bibo_queue.sv
module sim_bibo_queue;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int DW = 16;

   localparam logic [3:0] OP_WR   = 4'd0;
   localparam logic [3:0] OP_PUSH = 4'd1;
   localparam logic [3:0] OP_PULL = 4'd2;
   localparam logic [3:0] OP_RD   = 4'd3;
   localparam logic [3:0] OP_PP   = 4'd4;

   // Vector fields: op, arg (offset or size), data, expected level, expected error, requirement.
   function automatic logic [43:0] v(logic [3:0] op, logic [7:0] arg, logic [15:0] dat,
                                     logic [7:0] lvl, logic err, logic [6:0] req);
      return {op, arg, dat, lvl, err, req};
   endfunction

   localparam int NV = 36;
   localparam logic [43:0] VEC [NV] = '{
      v(OP_WR,   8'd2,  16'hA0A2, 8'd0,  1'b0, 7'd2),   // R2 out of order
      v(OP_WR,   8'd0,  16'hA0A0, 8'd0,  1'b0, 7'd2),
      v(OP_WR,   8'd3,  16'hA0A3, 8'd0,  1'b0, 7'd2),
      v(OP_WR,   8'd1,  16'hA0A1, 8'd0,  1'b0, 7'd2),
      v(OP_RD,   8'd0,  16'h0000, 8'd0,  1'b1, 7'd7),   // R7 not yet pushed
      v(OP_PUSH, 8'd4,  16'h0000, 8'd4,  1'b0, 7'd2),
      v(OP_WR,   8'd1,  16'hB0B1, 8'd4,  1'b0, 7'd4),   // R4 second size
      v(OP_WR,   8'd0,  16'hB0B0, 8'd4,  1'b0, 7'd4),
      v(OP_PUSH, 8'd2,  16'h0000, 8'd6,  1'b0, 7'd4),
      v(OP_RD,   8'd3,  16'hA0A3, 8'd6,  1'b0, 7'd2),
      v(OP_RD,   8'd0,  16'hA0A0, 8'd6,  1'b0, 7'd2),
      v(OP_RD,   8'd5,  16'hB0B1, 8'd6,  1'b0, 7'd5),   // R5 merged run
      v(OP_RD,   8'd6,  16'h0000, 8'd6,  1'b1, 7'd7),   // R7 edge
      v(OP_PULL, 8'd1,  16'h0000, 8'd5,  1'b0, 7'd5),   // R5 split
      v(OP_RD,   8'd0,  16'hA0A1, 8'd5,  1'b0, 7'd3),   // R3 shift
      v(OP_RD,   8'd4,  16'hB0B1, 8'd5,  1'b0, 7'd3),
      v(OP_PULL, 8'd5,  16'h0000, 8'd0,  1'b0, 7'd5),   // R5 merge pull
      v(OP_PULL, 8'd1,  16'h0000, 8'd0,  1'b1, 7'd9),   // R9 empty
      v(OP_WR,   8'd11, 16'hC00B, 8'd0,  1'b0, 7'd12),  // R12 wraps
      v(OP_WR,   8'd10, 16'hC00A, 8'd0,  1'b0, 7'd12),
      v(OP_WR,   8'd9,  16'hC009, 8'd0,  1'b0, 7'd12),
      v(OP_WR,   8'd0,  16'hC000, 8'd0,  1'b0, 7'd12),
      v(OP_PUSH, 8'd12, 16'h0000, 8'd12, 1'b0, 7'd12),
      v(OP_RD,   8'd11, 16'hC00B, 8'd12, 1'b0, 7'd12),
      v(OP_RD,   8'd10, 16'hC00A, 8'd12, 1'b0, 7'd12),
      v(OP_RD,   8'd9,  16'hC009, 8'd12, 1'b0, 7'd12),
      v(OP_PUSH, 8'd5,  16'h0000, 8'd12, 1'b1, 7'd8),   // R8 free is 4
      v(OP_WR,   8'd4,  16'hDEAD, 8'd12, 1'b0, 7'd11),  // R11 lands on head
      v(OP_RD,   8'd0,  16'hC000, 8'd12, 1'b0, 7'd11),
      v(OP_WR,   8'd0,  16'hD000, 8'd12, 1'b0, 7'd10),  // R10 setup
      v(OP_PUSH, 8'd1,  16'h0000, 8'd13, 1'b0, 7'd10),
      v(OP_WR,   8'd0,  16'hE000, 8'd13, 1'b0, 7'd10),
      v(OP_PP,   8'd1,  16'h000C, 8'd2,  1'b0, 7'd10),  // push 1, pull 12
      v(OP_RD,   8'd0,  16'hD000, 8'd2,  1'b0, 7'd3),
      v(OP_RD,   8'd1,  16'hE000, 8'd2,  1'b0, 7'd3),
      v(OP_PULL, 8'd2,  16'h0000, 8'd0,  1'b0, 7'd3)
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_off = '0;
   logic [DW-1:0] wr_data = '0;
   logic          push_en = 1'b0;
   logic [AW:0]   push_size = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_off = '0;
   logic          pull_en = 1'b0;
   logic [AW:0]   pull_size = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          rd_err;
   logic          push_err;
   logic          pull_err;
   logic [AW:0]   level;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bibo_queue #(.ADDR_W(AW), .DATA_W(DW), .CLEAR_ON_RESET(1'b0)) u0 (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_off (wr_off), .wr_data (wr_data),
      .push_en (push_en), .push_size (push_size),
      .rd_en (rd_en), .rd_off (rd_off),
      .pull_en (pull_en), .pull_size (pull_size),
      .rd_valid (rd_valid), .rd_data (rd_data), .rd_err (rd_err),
      .push_err (push_err), .pull_err (pull_err), .level (level)
   );

   task automatic idle_inputs();
      wr_en = 1'b0; push_en = 1'b0; rd_en = 1'b0; pull_en = 1'b0;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reset_dut();
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      reset_dut();
      // R1 reset state
      check("R1 level", 32'(level), 32'd0);
      check("R1 flags", {28'd0, rd_valid, rd_err, push_err, pull_err}, 32'd0);

      foreach (VEC[i]) begin
         logic [3:0]  op;
         logic [7:0]  arg;
         logic [15:0] dat;
         logic [7:0]  lvl;
         logic        err;
         logic [6:0]  req;
         {op, arg, dat, lvl, err, req} = VEC[i];
         idle_inputs();
         case (op)
            OP_WR:   begin wr_en = 1'b1; wr_off = arg[AW-1:0]; wr_data = dat; end
            OP_PUSH: begin push_en = 1'b1; push_size = arg[AW:0]; end
            OP_PULL: begin pull_en = 1'b1; pull_size = arg[AW:0]; end
            OP_RD:   begin rd_en = 1'b1; rd_off = arg[AW-1:0]; end
            default: begin
               push_en = 1'b1; push_size = arg[AW:0];
               pull_en = 1'b1; pull_size = dat[AW:0];
            end
         endcase
         @(negedge clk);
         n_vec++;
         if (op == OP_RD) begin
            if (level !== lvl[AW:0] || rd_valid !== 1'b1 || rd_data !== dat || rd_err !== err) begin
               n_bad++;
               $display("FAIL R%0d vec %0d: actual lvl=%0d vld=%b data=%h err=%b expected lvl=%0d vld=1 data=%h err=%b",
                        req, i, level, rd_valid, rd_data, rd_err, lvl, dat, err);
            end
         end else begin
            if (level !== lvl[AW:0] || (push_err | pull_err) !== err) begin
               n_bad++;
               $display("FAIL R%0d vec %0d: actual lvl=%0d err=%b expected lvl=%0d err=%b",
                        req, i, level, push_err | pull_err, lvl, err);
            end
         end
      end
      idle_inputs();

      // R6 valid strobe appears once and then drops
      @(negedge clk);
      rd_en = 1'b1; rd_off = '0;
      @(negedge clk);
      rd_en = 1'b0;
      check("R6 valid after request", 32'(rd_valid), 32'd1);
      @(negedge clk);
      check("R6 valid without request", 32'(rd_valid), 32'd0);

      // R1 reset in the middle of traffic empties the queue
      wr_en = 1'b1; wr_off = '0; wr_data = 16'h1234;
      @(negedge clk);
      idle_inputs(); push_en = 1'b1; push_size = 5'd3;
      @(negedge clk);
      idle_inputs();
      check("R4 level before reset", 32'(level), 32'd3);
      reset_dut();
      check("R1 level after reset", 32'(level), 32'd0);
      rd_en = 1'b1; rd_off = '0;
      @(negedge clk);
      idle_inputs();
      check("R1 read after reset", {15'd0, rd_err, rd_data}, {15'd0, 1'b1, 16'h0000});

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL R1 watchdog: actual done=0 expected done=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule